// File: doc/BRIEF.md
# Protection Region Match and Attribute Lookup

This block decides, for one memory access, which of eight programmable protection regions covers the access address, and it reports that region's attributes. Each region is an inclusive address window at 32-byte granularity. A region's lower bound is a 27-bit page number followed by five zero bits. Its upper bound is a 27-bit page number followed by five one bits. A region takes part only while its enable bit is set. The matching region's 3-bit attribute selector picks one byte out of a shared table of eight attribute bytes. The region's access-permission, shareability and no-execute fields are passed through.

The unit is steered by three control bits: a global on switch, a background-map permit for privileged accesses, and a permit to keep checking while a negative-priority handler runs. It is also steered by flags that come with each access: privileged, instruction fetch, and negative-priority handler. When checking is bypassed, or when a privileged miss falls back to the default map, the block raises a background flag. A miss by unprivileged code, an address covered by more than one region, and an instruction fetch from a no-execute region all raise the fault flag. The inputs are sampled on one clock edge and all outputs are registered, so the verdict appears one cycle after the access is presented.

Top module: `rg_access_check`

## Requirements
- R1: A synchronous active-high reset clears every output to zero.
- R2: A region covers the byte addresses from {lo,5'b00000} to {hi,5'b11111} inclusive, where lo and hi are its 27-bit page numbers. The verdict for an access appears on the outputs one clock after the access is presented.
- R3: A region whose enable bit is 0 never matches.
- R4: When exactly one region matches, hit_o is 1 and region_o carries that region's index. perm_o, share_o and noexec_o copy that region's 2-bit, 2-bit and 1-bit fields. attr_o is byte k of attr_tbl_i, which sits at bits [8k+7:8k], where k is the region's 3-bit selector.
- R5: When two or more enabled regions match, fault_o is 1 and hit_o is 0.
- R6: When ctl_on_i is 0, every access gives bg_o=1, fault_o=0 and hit_o=0.
- R7: An access with acc_hipri_i=1 is treated as in R6 when ctl_hinmi_i is 0. When ctl_hinmi_i is 1, the access is checked normally.
- R8: A privileged access that matches no region gives bg_o=1 and fault_o=0 if ctl_bg_priv_i is 1. Otherwise it gives fault_o=1.
- R9: An unprivileged access that matches no region always gives fault_o=1 and bg_o=0, whatever the value of ctl_bg_priv_i.
- R10: A single-region hit gives fault_o=1 exactly when acc_fetch_i=1 and the region's no-execute bit is 1. hit_o stays 1 in that case.
- R11: While hit_o is 0, region_o, attr_o, perm_o, share_o and noexec_o are all 0. bg_o is never 1 together with hit_o or with fault_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr_i | input | 32 | Access byte address |
| acc_priv_i | input | 1 | Access is privileged |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_hipri_i | input | 1 | Access comes from a negative-priority handler |
| ctl_on_i | input | 1 | Global checking enable |
| ctl_bg_priv_i | input | 1 | Default map allowed as background for privileged misses |
| ctl_hinmi_i | input | 1 | Keep checking during negative-priority handlers |
| rgn_en_i | input | 8 | Per-region enable, bit i for region i |
| rgn_lo_i | input | 216 | Lower page numbers, region i at bits [27i+26:27i] |
| rgn_hi_i | input | 216 | Upper page numbers, region i at bits [27i+26:27i] |
| rgn_sel_i | input | 24 | Attribute selectors, region i at bits [3i+2:3i] |
| rgn_perm_i | input | 16 | Access-permission fields, region i at bits [2i+1:2i] |
| rgn_share_i | input | 16 | Shareability fields, region i at bits [2i+1:2i] |
| rgn_noexec_i | input | 8 | No-execute bit, bit i for region i |
| attr_tbl_i | input | 64 | Eight attribute bytes, byte k at bits [8k+7:8k] |
| hit_o | output | 1 | Exactly one region matched |
| region_o | output | 3 | Index of the matched region |
| attr_o | output | 8 | Attribute byte of the matched region |
| perm_o | output | 2 | Access-permission field of the matched region |
| share_o | output | 2 | Shareability field of the matched region |
| noexec_o | output | 1 | No-execute bit of the matched region |
| bg_o | output | 1 | Default map used (bypass or privileged background) |
| fault_o | output | 1 | Access faults |

## Verification
The hardest cases to reach from the ports are the exact edges of a window and overlapping regions. The bench places a window and probes the first and last byte inside it and the byte just outside each end. It then lays a second enabled region over part of the first and probes both the shared bytes and the bytes only one region covers. Each control mode is probed with the same address, so the verdicts differ only because of the control and access flags. Expected outputs come from a reference function that the bench builds from the requirements.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [2:0] {
    VD_BYPASS,
    VD_REGION,
    VD_BACKGROUND,
    VD_FAULT_MISS,
    VD_FAULT_MULTI
  } verdict_e;
endpackage

// File: rtl/rg_region_cmp.sv
module rg_region_cmp #(
  parameter int PAGE_W = 27
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] lo_i,
  input  logic [PAGE_W-1:0] hi_i,
  input  logic              en_i,
  output logic              match_o
);
  logic above_lo;
  logic below_hi;

  // Comparing page numbers is the same as comparing {lo,00000} <= a <= {hi,11111}.
  assign above_lo = (page_i >= lo_i);
  assign below_hi = (page_i <= hi_i);
  assign match_o  = en_i & above_lo & below_hi;
endmodule

// File: rtl/rg_match_encode.sv
module rg_match_encode #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     match_i,
  output logic             any_o,
  output logic             multi_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o   = |match_i;
  // Clearing the lowest set bit leaves a one only when two or more bits were set.
  assign multi_o = |(match_i & (match_i - N'(1)));

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rg_attr_mux.sv
module rg_attr_mux #(
  parameter int NUM_ATTR = 8,
  parameter int ATTR_W   = 8,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_ATTR*ATTR_W-1:0] tbl_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [ATTR_W-1:0]          attr_o
);
  logic [ATTR_W-1:0] entry [NUM_ATTR];

  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_entry
    assign entry[k] = tbl_i[k*ATTR_W +: ATTR_W];
  end

  always_comb begin
    attr_o = '0;
    for (int k = 0; k < NUM_ATTR; k++) begin
      if (sel_i == SEL_W'(k)) attr_o = entry[k];
    end
  end
endmodule

// File: rtl/rg_access_check.sv
module rg_access_check #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int NUM_ATTR    = 8,
  parameter int ATTR_W      = 8,
  localparam int PAGE_W     = ADDR_W - GRAN_BITS,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int SEL_W      = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             acc_addr_i,
  input  logic                          acc_priv_i,
  input  logic                          acc_fetch_i,
  input  logic                          acc_hipri_i,
  input  logic                          ctl_on_i,
  input  logic                          ctl_bg_priv_i,
  input  logic                          ctl_hinmi_i,
  input  logic [NUM_REGIONS-1:0]        rgn_en_i,
  input  logic [NUM_REGIONS*PAGE_W-1:0] rgn_lo_i,
  input  logic [NUM_REGIONS*PAGE_W-1:0] rgn_hi_i,
  input  logic [NUM_REGIONS*SEL_W-1:0]  rgn_sel_i,
  input  logic [NUM_REGIONS*2-1:0]      rgn_perm_i,
  input  logic [NUM_REGIONS*2-1:0]      rgn_share_i,
  input  logic [NUM_REGIONS-1:0]        rgn_noexec_i,
  input  logic [NUM_ATTR*ATTR_W-1:0]    attr_tbl_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              region_o,
  output logic [ATTR_W-1:0]             attr_o,
  output logic [1:0]                    perm_o,
  output logic [1:0]                    share_o,
  output logic                          noexec_o,
  output logic                          bg_o,
  output logic                          fault_o
);
  import rg_pkg::*;

  logic [PAGE_W-1:0]      page;
  logic [NUM_REGIONS-1:0] match;
  logic                   any_m;
  logic                   multi_m;
  logic [IDX_W-1:0]       win;
  logic [SEL_W-1:0]       win_sel;
  logic [ATTR_W-1:0]      win_attr;
  logic                   bypass;
  verdict_e               verdict;

  assign page = acc_addr_i[ADDR_W-1:GRAN_BITS];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
    rg_region_cmp #(.PAGE_W(PAGE_W)) u_cmp (
      .page_i  (page),
      .lo_i    (rgn_lo_i[i*PAGE_W +: PAGE_W]),
      .hi_i    (rgn_hi_i[i*PAGE_W +: PAGE_W]),
      .en_i    (rgn_en_i[i]),
      .match_o (match[i])
    );
  end

  rg_match_encode #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_enc (
    .match_i (match),
    .any_o   (any_m),
    .multi_o (multi_m),
    .idx_o   (win)
  );

  assign win_sel = rgn_sel_i[win*SEL_W +: SEL_W];

  rg_attr_mux #(.NUM_ATTR(NUM_ATTR), .ATTR_W(ATTR_W), .SEL_W(SEL_W)) u_attr (
    .tbl_i  (attr_tbl_i),
    .sel_i  (win_sel),
    .attr_o (win_attr)
  );

  // Checking is skipped entirely when off, or for high-priority handlers without permit.
  assign bypass = ~ctl_on_i | (acc_hipri_i & ~ctl_hinmi_i);

  always_comb begin
    if (bypass)                      verdict = VD_BYPASS;
    else if (multi_m)                verdict = VD_FAULT_MULTI;
    else if (any_m)                  verdict = VD_REGION;
    else if (acc_priv_i && ctl_bg_priv_i) verdict = VD_BACKGROUND;
    else                             verdict = VD_FAULT_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o    <= 1'b0;
      region_o <= '0;
      attr_o   <= '0;
      perm_o   <= '0;
      share_o  <= '0;
      noexec_o <= 1'b0;
      bg_o     <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      hit_o    <= 1'b0;
      region_o <= '0;
      attr_o   <= '0;
      perm_o   <= '0;
      share_o  <= '0;
      noexec_o <= 1'b0;
      bg_o     <= 1'b0;
      fault_o  <= 1'b0;
      unique case (verdict)
        VD_BYPASS, VD_BACKGROUND: bg_o <= 1'b1;
        VD_FAULT_MISS, VD_FAULT_MULTI: fault_o <= 1'b1;
        VD_REGION: begin
          hit_o    <= 1'b1;
          region_o <= win;
          attr_o   <= win_attr;
          perm_o   <= rgn_perm_i[win*2 +: 2];
          share_o  <= rgn_share_i[win*2 +: 2];
          noexec_o <= rgn_noexec_i[win];
          fault_o  <= acc_fetch_i & rgn_noexec_i[win];
        end
        default: fault_o <= 1'b1;
      endcase
    end
  end
endmodule

module rg_access_check_sva #(
  parameter int IDX_W  = 3,
  parameter int ATTR_W = 8,
  parameter int NUM_REGIONS = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_priv_i,
  input logic                   acc_fetch_i,
  input logic                   acc_hipri_i,
  input logic                   ctl_on_i,
  input logic                   ctl_hinmi_i,
  input logic [NUM_REGIONS-1:0] rgn_en_i,
  input logic                   hit_o,
  input logic [IDX_W-1:0]       region_o,
  input logic [ATTR_W-1:0]      attr_o,
  input logic [1:0]             perm_o,
  input logic [1:0]             share_o,
  input logic                   noexec_o,
  input logic                   bg_o,
  input logic                   fault_o
);
  a_r6_off_bypasses: assert property (@(posedge clk) disable iff (rst)
    !ctl_on_i |=> (bg_o && !fault_o && !hit_o));

  a_r7_hipri_bypasses: assert property (@(posedge clk) disable iff (rst)
    (acc_hipri_i && !ctl_hinmi_i) |=> (bg_o && !fault_o && !hit_o));

  a_r9_unpriv_miss_faults: assert property (@(posedge clk) disable iff (rst)
    (ctl_on_i && !(acc_hipri_i && !ctl_hinmi_i) && !acc_priv_i && rgn_en_i == '0)
      |=> (fault_o && !hit_o && !bg_o));

  a_r3_none_enabled_no_hit: assert property (@(posedge clk) disable iff (rst)
    (rgn_en_i == '0) |=> !hit_o);

  a_r10_fetch_noexec: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (fault_o == (noexec_o && $past(acc_fetch_i))));

  a_r11_miss_fields_zero: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (region_o == '0 && attr_o == '0 && perm_o == '0 &&
                share_o == '0 && !noexec_o));

  a_r11_bg_exclusive: assert property (@(posedge clk) disable iff (rst)
    bg_o |-> (!hit_o && !fault_o));

  a_r5_multi_no_hit: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !noexec_o) |-> !fault_o);
endmodule

bind rg_access_check rg_access_check_sva #(
  .IDX_W(IDX_W), .ATTR_W(ATTR_W), .NUM_REGIONS(NUM_REGIONS)
) u_sva (.*);

// File: tb/rg_access_check_test.sv
`timescale 1ns/1ps
module rg_access_check_test;
  localparam int NR = 8;
  localparam int PW = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] addr;
  logic priv, fetch, hipri, on, bgp, hinmi;
  logic [PW-1:0] lo_a [NR];
  logic [PW-1:0] hi_a [NR];
  logic [2:0]    sel_a [NR];
  logic [1:0]    perm_a [NR];
  logic [1:0]    share_a [NR];
  logic [NR-1:0] en, nx;
  logic [63:0]   tbl;
  logic [NR*PW-1:0] lo_f, hi_f;
  logic [NR*3-1:0]  sel_f;
  logic [NR*2-1:0]  perm_f, share_f;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      lo_f[i*PW +: PW]  = lo_a[i];
      hi_f[i*PW +: PW]  = hi_a[i];
      sel_f[i*3 +: 3]   = sel_a[i];
      perm_f[i*2 +: 2]  = perm_a[i];
      share_f[i*2 +: 2] = share_a[i];
    end
  end

  logic hit, nxo, bg, fault;
  logic [2:0] rgn;
  logic [7:0] attr;
  logic [1:0] perm, share;

  rg_access_check uut (
    .clk(clk), .rst(rst), .acc_addr_i(addr), .acc_priv_i(priv),
    .acc_fetch_i(fetch), .acc_hipri_i(hipri), .ctl_on_i(on),
    .ctl_bg_priv_i(bgp), .ctl_hinmi_i(hinmi), .rgn_en_i(en),
    .rgn_lo_i(lo_f), .rgn_hi_i(hi_f), .rgn_sel_i(sel_f),
    .rgn_perm_i(perm_f), .rgn_share_i(share_f), .rgn_noexec_i(nx),
    .attr_tbl_i(tbl), .hit_o(hit), .region_o(rgn), .attr_o(attr),
    .perm_o(perm), .share_o(share), .noexec_o(nxo), .bg_o(bg), .fault_o(fault)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  typedef struct packed {
    logic hit; logic [2:0] rgn; logic [7:0] attr; logic [1:0] perm;
    logic [1:0] share; logic nx; logic bg; logic fault;
  } exp_t;

  // Reference verdict built from the requirements.
  function automatic exp_t model(logic [31:0] a, logic p, logic f, logic h);
    exp_t e = '0;
    int cnt = 0;
    int w = 0;
    for (int i = 0; i < NR; i++)
      if (en[i] && a[31:5] >= lo_a[i] && a[31:5] <= hi_a[i]) begin
        cnt++;
        w = i;
      end
    if (!on || (h && !hinmi)) e.bg = 1'b1;
    else if (cnt == 1) begin
      e.hit = 1'b1; e.rgn = 3'(w); e.attr = tbl[sel_a[w]*8 +: 8];
      e.perm = perm_a[w]; e.share = share_a[w]; e.nx = nx[w];
      e.fault = f && nx[w];
    end
    else if (cnt > 1) e.fault = 1'b1;
    else if (p && bgp) e.bg = 1'b1;
    else e.fault = 1'b1;
    return e;
  endfunction

  task automatic probe(string req, logic [31:0] a, logic p, logic f, logic h);
    exp_t e;
    @(negedge clk);
    addr = a; priv = p; fetch = f; hipri = h;
    e = model(a, p, f, h);
    @(negedge clk);
    chk(req, "hit", 32'(hit), 32'(e.hit));
    chk(req, "region", 32'(rgn), 32'(e.rgn));
    chk(req, "attr", 32'(attr), 32'(e.attr));
    chk(req, "perm", 32'(perm), 32'(e.perm));
    chk(req, "share", 32'(share), 32'(e.share));
    chk(req, "noexec", 32'(nxo), 32'(e.nx));
    chk(req, "bg", 32'(bg), 32'(e.bg));
    chk(req, "fault", 32'(fault), 32'(e.fault));
  endtask

  task automatic setup_regions();
    for (int i = 0; i < NR; i++) begin
      lo_a[i] = PW'(32'h1000 * (i + 1));
      hi_a[i] = PW'(32'h1000 * (i + 1) + 32'h0FF);
      sel_a[i] = 3'(7 - i);
      perm_a[i] = 2'(i);
      share_a[i] = 2'(i + 1);
    end
    en = 8'hFF; nx = 8'b0100_0000;
    tbl = 64'hF7E6D5C4B3A29180;
    on = 1'b1; bgp = 1'b0; hinmi = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; addr = 32'h0002_0000; priv = 1'b1; fetch = 1'b0; hipri = 1'b0;
    @(negedge clk);
    chk("R1", "hit", 32'(hit), 0);
    chk("R1", "attr", 32'(attr), 0);
    chk("R1", "bg", 32'(bg), 0);
    chk("R1", "fault", 32'(fault), 0);
    rst = 1'b0;
  endtask

  task automatic t_bounds();
    // Region 2: pages 0x3000..0x30FF, bytes 0x60000..0x61FFF.
    probe("R2", 32'h0006_0000, 1'b1, 1'b0, 1'b0);
    chk("R2", "first byte hit", 32'(hit), 1);
    probe("R2", 32'h0006_1FFF, 1'b1, 1'b0, 1'b0);
    chk("R2", "last byte hit", 32'(hit), 1);
    probe("R2", 32'h0005_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R2", "below miss", 32'(fault), 1);
    probe("R2", 32'h0006_2000, 1'b1, 1'b0, 1'b0);
    chk("R2", "above miss", 32'(fault), 1);
  endtask

  task automatic t_enable();
    en[2] = 1'b0;
    probe("R3", 32'h0006_0040, 1'b1, 1'b0, 1'b0);
    chk("R3", "disabled region hit", 32'(hit), 0);
    en[2] = 1'b1;
  endtask

  task automatic t_lookup();
    for (int i = 0; i < NR; i++) begin
      probe("R4", 32'(lo_a[i]) << 5 | 32'h10, 1'b0, 1'b0, 1'b0);
      chk("R4", "attr byte", 32'(attr), 32'(tbl[(7 - i)*8 +: 8]));
    end
  endtask

  task automatic t_overlap();
    hi_a[0] = lo_a[1] + PW'(4);
    probe("R5", 32'(lo_a[1]) << 5, 1'b1, 1'b0, 1'b0);
    chk("R5", "overlap fault", 32'(fault), 1);
    probe("R5", (32'(lo_a[1]) << 5) + 32'hA0, 1'b1, 1'b0, 1'b0);
    chk("R5", "past overlap hit", 32'(hit), 1);
    hi_a[0] = lo_a[0] + PW'(32'h0FF);
  endtask

  task automatic t_off();
    on = 1'b0;
    probe("R6", 32'h0006_0000, 1'b0, 1'b1, 1'b0);
    probe("R6", 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    chk("R6", "bg when off", 32'(bg), 1);
    on = 1'b1;
  endtask

  task automatic t_hipri();
    hinmi = 1'b0;
    probe("R7", 32'h0000_0000, 1'b0, 1'b0, 1'b1);
    chk("R7", "bypass bg", 32'(bg), 1);
    hinmi = 1'b1;
    probe("R7", 32'h0000_0000, 1'b0, 1'b0, 1'b1);
    chk("R7", "checked fault", 32'(fault), 1);
    probe("R7", 32'h0006_0000, 1'b0, 1'b0, 1'b1);
    hinmi = 1'b0;
  endtask

  task automatic t_background();
    bgp = 1'b1;
    probe("R8", 32'h0000_0100, 1'b1, 1'b0, 1'b0);
    chk("R8", "priv background", 32'(bg), 1);
    probe("R9", 32'h0000_0100, 1'b0, 1'b0, 1'b0);
    chk("R9", "unpriv fault with permit", 32'(fault), 1);
    bgp = 1'b0;
    probe("R8", 32'h0000_0100, 1'b1, 1'b0, 1'b0);
    chk("R8", "priv fault without permit", 32'(fault), 1);
    probe("R9", 32'h0000_0100, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_noexec();
    // Region 6 has no-execute set.
    probe("R10", 32'(lo_a[6]) << 5, 1'b1, 1'b1, 1'b0);
    chk("R10", "fetch fault", 32'(fault), 1);
    chk("R10", "hit kept", 32'(hit), 1);
    probe("R10", 32'(lo_a[6]) << 5, 1'b1, 1'b0, 1'b0);
    chk("R10", "data no fault", 32'(fault), 0);
    probe("R10", 32'(lo_a[5]) << 5, 1'b1, 1'b1, 1'b0);
    chk("R10", "fetch elsewhere ok", 32'(fault), 0);
  endtask

  task automatic t_zero_fields();
    probe("R11", 32'h0000_0020, 1'b1, 1'b0, 1'b0);
    chk("R11", "region zero on miss", 32'(rgn), 0);
  endtask

  initial begin
    setup_regions();
    addr = '0; priv = 0; fetch = 0; hipri = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_bounds();
    t_enable();
    t_lookup();
    t_overlap();
    t_off();
    t_hipri();
    t_background();
    t_noexec();
    t_zero_fields();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule